// File: doc/BRIEF.md
# Reference Pulse Capture Controller

This block watches a single-bit system reference line that arrives asynchronously to the device clock. It turns each qualifying transition of that line into a pulse that lasts exactly one clock cycle. Timing logic further down the chip uses this pulse to align itself.

Software controls the block through one 8-bit control register. The fields in that register select:
- which direction of transition counts as valid,
- whether the line is sampled on the rising or the falling clock edge,
- whether capture is continuous or one-shot.

In continuous mode, every valid transition produces a pulse. In one-shot mode, the block arms when software sets the enable bit. It then accepts one valid transition and clears the enable bit in hardware. Any later transitions have no effect until software arms the block again.

The sampled level always passes through a configurable synchroniser in the rising-edge domain before edge detection. This keeps the output pulse one rising-edge cycle wide in both sampling modes.

Top module: `refpulse_ctrl`

## Requirements
- R1: During and after reset, the control register reads 0x00 and the alignment pulse is low.
- R2: A write stores wr_data bits 4..1 into the control register. The field positions are:
  - bit 4: transition select (1 = high-to-low)
  - bit 3: capture edge (1 = falling clock edge)
  - bit 2: one-shot mode
  - bit 1: enable

  Bits 7..5 and bit 0 always read 0. The stored value appears on rd_data in the cycle after the write.
- R3: With transition select 0, a low-to-high change of the reference produces a pulse, and a high-to-low change produces none.
- R4: With transition select 1, a high-to-low change produces a pulse, and a low-to-high change produces none.
- R5: With rising-edge capture, a reference change between rising edges k and k+1 raises the pulse at rising edge k+SYNC_STAGES+2.
- R6: With falling-edge capture, the reference is sampled on the falling clock edge:
  - A change before the falling edge of cycle k gives the R5 latency.
  - A change after that falling edge gives the R5 latency plus one cycle.
- R7: The alignment pulse is never high for two consecutive cycles.
- R8: While the enable bit is 0, no pulse is produced, whatever the reference does.
- R9: In continuous mode (bit 2 = 0), every valid transition produces a pulse and the enable bit stays set.
- R10: In one-shot mode (bit 2 = 1), the first valid transition produces a pulse and clears the enable bit at the same clock edge. Later transitions produce no pulse.
- R11: Enabling capture while the reference already rests at its active level produces no pulse.
- R12: A software write in the same cycle as the hardware clear wins: the written enable value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | External system reference line |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Current control register contents |
| align_pulse | output | 1 | One-cycle alignment pulse |

## Verification
A reference change made just after rising edge k is due on align_pulse after rising edge k+4 with the default two synchroniser stages. With falling-edge capture, a change placed after the falling edge arrives one cycle later. Register writes show on rd_data in the cycle after the strobe.

The driver records the exact cycle each pulse is due in a scoreboard queue. The monitor samples 5 ns before each rising edge and checks each pulse against the head of that queue. Any missed, early or extra pulse counts as a failure, as does a high level in the cycle after a matched pulse. The same-cycle write test places the write strobe in the one cycle that ends at the hardware-clear edge.

// File: rtl/refpulse_pkg.sv
package refpulse_pkg;

    localparam int CTRL_W      = 8;
    localparam int POS_ENABLE  = 1;
    localparam int POS_ONESHOT = 2;
    localparam int POS_CAPFALL = 3;
    localparam int POS_POLFALL = 4;

    typedef struct packed {
        logic pol_fall;
        logic cap_fall;
        logic one_shot;
        logic enable;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] raw);
        ctrl_t c;
        c.pol_fall = raw[POS_POLFALL];
        c.cap_fall = raw[POS_CAPFALL];
        c.one_shot = raw[POS_ONESHOT];
        c.enable   = raw[POS_ENABLE];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] raw;
        raw              = '0;
        raw[POS_POLFALL] = c.pol_fall;
        raw[POS_CAPFALL] = c.cap_fall;
        raw[POS_ONESHOT] = c.one_shot;
        raw[POS_ENABLE]  = c.enable;
        return raw;
    endfunction

endpackage

// File: rtl/refpulse_cfg.sv
module refpulse_cfg
    import refpulse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              hw_clear,
    output ctrl_t             cfg,
    output logic [CTRL_W-1:0] rd_data
);

    ctrl_t cfg_d, cfg_q;

    // Hardware clear first, software write last: the write wins.
    always_comb begin
        cfg_d = cfg_q;
        if (hw_clear) begin
            cfg_d.enable = 1'b0;
        end
        if (wr_en) begin
            cfg_d = ctrl_unpack(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg     = cfg_q;
    assign rd_data = ctrl_pack(cfg_q);

endmodule

// File: rtl/refpulse_sampler.sv
module refpulse_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic cap_fall,
    output logic sample
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic                   rise;
        logic                   fall_rt;
        logic [SYNC_STAGES-1:0] sync;
    } samp_t;

    samp_t st_d, st_q;
    logic  fall_q;
    logic  picked;
    logic [CHAIN_W-1:0] chain;

    // Falling-edge capture flop; retimed into the rising domain below.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= ref_in;
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.rise    = ref_in;
        st_d.fall_rt = fall_q;
        picked       = cap_fall ? st_q.fall_rt : st_q.rise;
        chain        = {st_q.sync, picked};
        st_d.sync    = chain[SYNC_STAGES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample = st_q.sync[SYNC_STAGES-1];

endmodule

// File: rtl/refpulse_edge_det.sv
module refpulse_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic enable,
    input  logic pol_fall,
    output logic hit,
    output logic pulse
);

    typedef struct packed {
        logic prev;
        logic armed;
        logic pulse;
    } edge_t;

    edge_t st_d, st_q;
    logic  rise_seen;
    logic  fall_seen;

    always_comb begin
        rise_seen = sample & ~st_q.prev;
        fall_seen = ~sample & st_q.prev;
        hit       = enable & st_q.armed & (pol_fall ? fall_seen : rise_seen);

        st_d       = st_q;
        st_d.prev  = sample;
        // History is only trusted after one enabled cycle.
        st_d.armed = enable;
        st_d.pulse = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

endmodule

// File: rtl/refpulse_ctrl.sv
module refpulse_ctrl
    import refpulse_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              align_pulse
);

    ctrl_t cfg;
    logic  sample;
    logic  hit;
    logic  hw_clear;

    assign hw_clear = hit & cfg.one_shot;

    refpulse_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .hw_clear (hw_clear),
        .cfg      (cfg),
        .rd_data  (rd_data)
    );

    refpulse_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .cap_fall (cfg.cap_fall),
        .sample   (sample)
    );

    refpulse_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .enable   (cfg.enable),
        .pol_fall (cfg.pol_fall),
        .hit      (hit),
        .pulse    (align_pulse)
    );

endmodule

// File: rtl/refpulse_ctrl_chk.sv
module refpulse_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       align_pulse
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_state_r1: assert (rd_data == 8'h00 && !align_pulse)
                else $error("reset state violated");
        end
    end

    p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == ($past(wr_data) & 8'h1E)));

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        align_pulse |=> !align_pulse);

    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[1] |=> !align_pulse);

    p_continuous_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (align_pulse && !$past(rd_data[2]) && !$past(wr_en)) |-> rd_data[1]);

    p_oneshot_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (align_pulse && $past(rd_data[2]) && !$past(wr_en)) |-> !rd_data[1]);

    p_sw_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1]) |=> rd_data[1]);

endmodule

bind refpulse_ctrl refpulse_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .align_pulse (align_pulse)
);

// File: tb/refpulse_ctrl_tb.sv
module refpulse_ctrl_tb;

    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 2;

    typedef struct {
        int    cyc;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       align_pulse;

    int    cyc = 0;
    int    total = 0;
    int    fails = 0;
    int    pulse_count = 0;
    bit    done = 1'b0;
    bit    low_chk = 1'b0;
    string phase = "R1";
    exp_t  q[$];

    refpulse_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_in      (ref_in),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .align_pulse (align_pulse)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: 5 ns before each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #15;
            if (rst_n) begin
                if (low_chk) begin
                    total++;
                    low_chk = 1'b0;
                    if (align_pulse) begin
                        fails++;
                        $display("FAIL R7 pulse wide at cycle %0d: actual 1 expected 0", cyc);
                    end
                end else if (align_pulse) begin
                    pulse_count++;
                    total++;
                    if (q.size() > 0 && q[0].cyc == cyc) begin
                        void'(q.pop_front());
                        low_chk = 1'b1;
                    end else begin
                        fails++;
                        $display("FAIL %s unexpected pulse: actual cycle %0d expected none", phase, cyc);
                    end
                end
                while (q.size() > 0 && q[0].cyc < cyc) begin
                    total++;
                    fails++;
                    $display("FAIL %s missing pulse: actual none expected cycle %0d", q[0].tag, q[0].cyc);
                    void'(q.pop_front());
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic drive(input logic v, input int delay, input string tag);
        exp_t e;
        ref_in = v;
        if (delay > 0) begin
            e.cyc = cyc + delay;
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        step(1);
        wr_en   = 1'b1;
        wr_data = v;
        step(1);
        wr_en   = 1'b0;
    endtask

    task automatic check_reg(input logic [7:0] exp, input string tag);
        total++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s rd_data: actual %02h expected %02h", tag, rd_data, exp);
        end
    endtask

    task automatic check_count(input int base, input int exp, input string tag);
        total++;
        if (pulse_count - base != exp) begin
            fails++;
            $display("FAIL %s pulse count: actual %0d expected %0d", tag, pulse_count - base, exp);
        end
    endtask

    initial begin
        #200000000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired: actual hang expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int base;
        step(3);
        check_reg(8'h00, "R1");
        total++;
        if (align_pulse !== 1'b0) begin
            fails++;
            $display("FAIL R1 pulse in reset: actual %0b expected 0", align_pulse);
        end
        rst_n = 1'b1;
        step(2);
        check_reg(8'h00, "R1");

        // R8: disabled, toggles ignored
        phase = "R8";
        base = pulse_count;
        drive(1'b1, 0, "R8"); step(8);
        drive(1'b0, 0, "R8"); step(8);
        drive(1'b1, 0, "R8"); step(8);
        drive(1'b0, 0, "R8"); step(8);
        check_count(base, 0, "R8");

        // R2: field storage, unused bits read 0
        phase = "R2";
        write_reg(8'hFF);
        check_reg(8'h1E, "R2");
        write_reg(8'h02);
        check_reg(8'h02, "R2");
        step(4);

        // R3 / R5 / R9: rising transitions, rising capture, continuous
        phase = "R3";
        base = pulse_count;
        drive(1'b1, LAT, "R5"); step(8);
        drive(1'b0, 0, "R3");   step(8);
        drive(1'b1, LAT, "R9"); step(8);
        drive(1'b0, 0, "R3");   step(7);
        #10;
        drive(1'b1, LAT, "R5");  // late in cycle, still rising-edge latency
        step(8);
        drive(1'b0, 0, "R3");   step(8);
        check_count(base, 3, "R3");
        check_reg(8'h02, "R9");

        // R4: falling transitions
        phase = "R4";
        write_reg(8'h12);
        step(4);
        base = pulse_count;
        drive(1'b1, 0, "R4");   step(8);
        drive(1'b0, LAT, "R4"); step(8);
        check_count(base, 1, "R4");

        // R6: falling clock edge capture
        phase = "R6";
        write_reg(8'h0A);
        step(4);
        base = pulse_count;
        drive(1'b1, LAT, "R6"); step(8);
        drive(1'b0, 0, "R6");   step(7);
        #10;
        drive(1'b1, LAT + 1, "R6");
        step(8);
        drive(1'b0, 0, "R6");   step(8);
        check_count(base, 2, "R6");

        // R10: one-shot
        phase = "R10";
        write_reg(8'h06);
        check_reg(8'h06, "R10");
        step(4);
        base = pulse_count;
        drive(1'b1, LAT, "R10"); step(8);
        check_reg(8'h04, "R10");
        drive(1'b0, 0, "R10"); step(8);
        drive(1'b1, 0, "R10"); step(8);
        drive(1'b0, 0, "R10"); step(8);
        check_count(base, 1, "R10");

        // R11: enable while reference sits at active level
        phase = "R11";
        drive(1'b1, 0, "R11"); step(8);
        base = pulse_count;
        write_reg(8'h02);
        step(10);
        check_count(base, 0, "R11");
        drive(1'b0, 0, "R11");   step(8);
        drive(1'b1, LAT, "R11"); step(8);
        check_count(base, 1, "R11");

        // R12: write coincides with hardware clear
        phase = "R12";
        write_reg(8'h06);
        drive(1'b0, 0, "R12"); step(8);
        base = pulse_count;
        drive(1'b1, LAT, "R12");
        step(LAT - 1);
        wr_en   = 1'b1;
        wr_data = 8'h06;
        step(1);
        wr_en   = 1'b0;
        check_reg(8'h06, "R12");
        step(4);
        drive(1'b0, 0, "R12");   step(8);
        drive(1'b1, LAT, "R12"); step(8);
        check_reg(8'h04, "R12");
        check_count(base, 2, "R12");

        step(10);
        while (q.size() > 0) begin
            total++;
            fails++;
            $display("FAIL %s missing pulse: actual none expected cycle %0d", q[0].tag, q[0].cyc);
            void'(q.pop_front());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule